// File: doc/BRIEF.md
# Multiplexed-Bus Glue and Address Decoder

This block sits between a 16-bit-address processor that time-shares its data bus with the upper address byte and the memories and peripheral around it. While the processor clock (`phi2`) is low, the data bus carries the bank byte. The block captures that byte on the rising clock edge and holds it, which extends the address to 24 bits. It then produces active-low selects for a ROM, a RAM and one peripheral.

Every select depends on a valid-cycle qualifier. That qualifier is true when either of the processor's two address-valid status lines (`vda`, `vpa`) is high. The RAM write strobe and the shared memory output enable are both qualified by the clock being high. The chip selects are not. The peripheral receives the processor's read/write line unchanged.

Reset is asynchronous and active low. Its release is synchronised to the rising edge of `phi2` through two stages.

Top module: `cpu_bus_glue`

## Requirements
- R1: When `vda` and `vpa` are both low, `rom_cs_n`, `ram_cs_n` and `io_cs_n` are all 1.
- R2: While `phi2` is low, `bank_o` follows `data_i`. While `phi2` is high, `bank_o` holds the value `data_i` had at the rising edge of `phi2`.
- R3: In bank 0, a valid cycle selects a region from the address:
  - addresses 0x0000 to 0x7EFF select RAM (`ram_cs_n`=0);
  - addresses 0x7F00 to 0x7FFF select the peripheral (`io_cs_n`=0);
  - addresses 0x8000 to 0xFFFF select ROM (`rom_cs_n`=0).
- R4: In any bank other than 0, a valid cycle selects RAM for every address.
- R5: Chip selects are not gated by `phi2`. During a valid cycle they are already asserted while `phi2` is low.
- R6: `ram_we_n` is 0 only when all of the following hold: `phi2` is high, `rwb` is 0, the cycle is valid and RAM is selected.
- R7: `io_rw` equals `rwb` at all times outside reset, whatever the state of `phi2` or the selects.
- R8: `mem_oe_n` is 0 only when all of the following hold: `phi2` is high, `rwb` is 1, the cycle is valid and RAM or ROM is selected.
- R9: A write cycle (`rwb`=0) to the ROM range asserts no write strobe (`ram_we_n` stays 1).
- R10: At most one of the three chip selects is 0 at any time.
- R11: While `rst_n` is 0, and until the second rising edge of `phi2` after it returns to 1, all of the following hold:
  - all selects and strobes are 1;
  - `io_rw` is 1;
  - `bank_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Processor clock; high phase is the data phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| rwb | input | 1 | Processor read (1) / write (0) |
| vda | input | 1 | Data-address-valid status |
| vpa | input | 1 | Program-address-valid status |
| addr_i | input | 16 | Low 16 address bits |
| data_i | input | 8 | Data bus; carries the bank byte while `phi2` is low |
| bank_o | output | 8 | Bank byte, transparent while low and held while high |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| io_cs_n | output | 1 | Peripheral select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low, clock-qualified |
| mem_oe_n | output | 1 | ROM/RAM output enable, active low |
| io_rw | output | 1 | Read/write line for the peripheral |

## Verification
The bench builds the block with its default parameters: an 8-bit bank, a 16-bit address, the peripheral window at 0x7F00 and ROM from 0x8000. This is small enough to cover every 256-byte page of the address space, plus the exact boundary addresses on both sides of each region edge. The sweep runs in banks 0x00, 0x01, 0x80 and 0xFF, under all four status-line combinations and both read and write. For every cycle it checks both clock phases: the low phase exposes the ungated selects and the transparent bank path, and the high phase exposes the captured bank, the write strobe and the output enable.

// File: rtl/glue_pkg.sv
`timescale 1ns/1ps
package glue_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_IO   = 2'd2,
    RGN_ROM  = 2'd3
  } region_e;

  localparam int NUM_SEL = 3;
  localparam int SEL_RAM = 0;
  localparam int SEL_IO  = 1;
  localparam int SEL_ROM = 2;
endpackage

// File: rtl/glue_reset_sync.sv
`timescale 1ns/1ps
module glue_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic phi2,
  input  logic rst_n,
  output logic active_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              sync_en;

  always_comb begin
    sync_en = 1'b1;
    sync_d  = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge phi2 or negedge rst_n) begin
    if (!rst_n)       sync_q <= '0;
    else if (sync_en) sync_q <= sync_d;
  end

  assign active_o = sync_q[STAGES-1];
endmodule

// File: rtl/glue_bank_capture.sv
`timescale 1ns/1ps
module glue_bank_capture #(
  parameter int BANK_W = 8
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;
  logic              cap_en;

  always_comb begin
    cap_en = 1'b1;
    bank_d = data_i;
  end

  always_ff @(posedge phi2 or negedge rst_n) begin
    if (!rst_n)      bank_q <= '0;
    else if (cap_en) bank_q <= bank_d;
  end

  always_comb begin
    if (!active_i)  bank_o = '0;
    else if (phi2)  bank_o = bank_q;
    else            bank_o = data_i;
  end
endmodule

// File: rtl/glue_addr_decode.sv
`timescale 1ns/1ps
module glue_addr_decode
  import glue_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          BANK_W   = 8,
  parameter logic [15:0] IO_BASE  = 16'h7F00,
  parameter logic [15:0] ROM_BASE = 16'h8000
) (
  input  logic              valid_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  localparam logic [ADDR_W-1:0] IO_LO  = ADDR_W'(IO_BASE);
  localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_BASE);

  logic low_bank;
  assign low_bank = (bank_i == '0);

  always_comb begin
    region_o = RGN_NONE;
    if (valid_i) begin
      if (!low_bank)            region_o = RGN_RAM;
      else if (addr_i >= ROM_LO) region_o = RGN_ROM;
      else if (addr_i >= IO_LO)  region_o = RGN_IO;
      else                       region_o = RGN_RAM;
    end
  end
endmodule

// File: rtl/glue_strobe_gen.sv
`timescale 1ns/1ps
module glue_strobe_gen
  import glue_pkg::*;
(
  input  logic               active_i,
  input  logic               phi2,
  input  logic               rwb,
  input  region_e            region_i,
  output logic [NUM_SEL-1:0] sel_n_o,
  output logic               ram_we_n,
  output logic               mem_oe_n,
  output logic               io_rw
);
  logic [NUM_SEL-1:0] hit;

  always_comb begin
    hit          = '0;
    hit[SEL_RAM] = (region_i == RGN_RAM);
    hit[SEL_IO]  = (region_i == RGN_IO);
    hit[SEL_ROM] = (region_i == RGN_ROM);
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign sel_n_o[g] = ~(active_i & hit[g]);
  end

  always_comb begin
    ram_we_n = ~(active_i & phi2 & ~rwb & hit[SEL_RAM]);
    mem_oe_n = ~(active_i & phi2 & rwb & (hit[SEL_RAM] | hit[SEL_ROM]));
    io_rw    = active_i ? rwb : 1'b1;
  end
endmodule

// File: rtl/cpu_bus_glue.sv
`timescale 1ns/1ps
module cpu_bus_glue
  import glue_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          BANK_W   = 8,
  parameter int          SYNC_LEN = 2,
  parameter logic [15:0] IO_BASE  = 16'h7F00,
  parameter logic [15:0] ROM_BASE = 16'h8000
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic              rwb,
  input  logic              vda,
  input  logic              vpa,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              io_cs_n,
  output logic              ram_we_n,
  output logic              mem_oe_n,
  output logic              io_rw
);
  logic               active;
  logic               valid;
  logic [BANK_W-1:0]  bank;
  region_e            region;
  logic [NUM_SEL-1:0] sel_n;

  assign valid = vda | vpa;

  glue_reset_sync #(.STAGES(SYNC_LEN)) u_rst (
    .phi2(phi2), .rst_n(rst_n), .active_o(active)
  );

  glue_bank_capture #(.BANK_W(BANK_W)) u_bank (
    .phi2(phi2), .rst_n(rst_n), .active_i(active), .data_i(data_i), .bank_o(bank)
  );

  glue_addr_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .IO_BASE(IO_BASE), .ROM_BASE(ROM_BASE)
  ) u_dec (
    .valid_i(valid), .bank_i(bank), .addr_i(addr_i), .region_o(region)
  );

  glue_strobe_gen u_strb (
    .active_i(active), .phi2(phi2), .rwb(rwb), .region_i(region),
    .sel_n_o(sel_n), .ram_we_n(ram_we_n), .mem_oe_n(mem_oe_n), .io_rw(io_rw)
  );

  assign bank_o   = bank;
  assign ram_cs_n = sel_n[SEL_RAM];
  assign io_cs_n  = sel_n[SEL_IO];
  assign rom_cs_n = sel_n[SEL_ROM];
endmodule

// File: rtl/cpu_bus_glue_chk.sv
`timescale 1ns/1ps
module cpu_bus_glue_chk (
  input logic phi2,
  input logic rst_n,
  input logic rwb,
  input logic vda,
  input logic vpa,
  input logic rom_cs_n,
  input logic ram_cs_n,
  input logic io_cs_n,
  input logic ram_we_n,
  input logic mem_oe_n,
  input logic io_rw
);
  // R10
  one_select_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    $countones({~rom_cs_n, ~ram_cs_n, ~io_cs_n}) <= 1);

  // R1
  invalid_cycle_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    !(vda || vpa) |-> (rom_cs_n && ram_cs_n && io_cs_n));

  // R6
  we_low_phase_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    ram_we_n && mem_oe_n);

  // R6
  we_needs_ram_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    !ram_we_n |-> (!ram_cs_n && !rwb));

  // R9
  rom_no_write_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    !rom_cs_n |-> ram_we_n);

  // R8
  oe_read_only_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    !mem_oe_n |-> (rwb && io_cs_n));

  // R7
  io_rw_raw_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    !io_rw |-> !rwb);
endmodule

bind cpu_bus_glue cpu_bus_glue_chk u_chk (
  .phi2(phi2), .rst_n(rst_n), .rwb(rwb), .vda(vda), .vpa(vpa),
  .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n),
  .ram_we_n(ram_we_n), .mem_oe_n(mem_oe_n), .io_rw(io_rw)
);

// File: tb/cpu_bus_glue_test.sv
`timescale 1ns/1ps
module cpu_bus_glue_test;
  logic        phi2 = 1'b0;
  logic        rst_n = 1'b0;
  logic        rwb = 1'b1, vda = 1'b0, vpa = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [7:0]  bank_o;
  logic        rom_cs_n, ram_cs_n, io_cs_n, ram_we_n, mem_oe_n, io_rw;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 phi2 = ~phi2;

  cpu_bus_glue uut (
    .phi2(phi2), .rst_n(rst_n), .rwb(rwb), .vda(vda), .vpa(vpa),
    .addr_i(addr), .data_i(data), .bank_o(bank_o),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n),
    .ram_we_n(ram_we_n), .mem_oe_n(mem_oe_n), .io_rw(io_rw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // region code: 0 none, 1 ram, 2 io, 3 rom
  function automatic int region_of(input logic [7:0] b, input logic [15:0] a, input logic v);
    if (!v) return 0;
    if (b != 8'h00) return 1;
    if (a >= 16'h8000) return 3;
    if (a >= 16'h7F00) return 2;
    return 1;
  endfunction

  task automatic check_cs(input string req, input int rgn);
    chk(req, {29'd0, rom_cs_n, ram_cs_n, io_cs_n},
        {29'd0, 1'(rgn != 3), 1'(rgn != 1), 1'(rgn != 2)});
    chk("R10", 32'($countones({~rom_cs_n, ~ram_cs_n, ~io_cs_n}) <= 1), 32'd1);
  endtask

  task automatic bus_cycle(input logic [7:0] b, input logic [15:0] a,
                           input logic da, input logic pa, input logic rw);
    int    rgn;
    string creq;
    @(negedge phi2);
    #2;
    data = b; addr = a; vda = da; vpa = pa; rwb = rw;
    rgn  = region_of(b, a, da | pa);
    creq = !(da | pa) ? "R1" : (b != 0) ? "R4" : "R5";
    #4;
    // low phase: transparent bank, ungated selects, no strobes
    chk("R2", 32'(bank_o), 32'(b));
    check_cs(creq, rgn);
    chk("R6", 32'(ram_we_n), 32'd1);
    chk("R8", 32'(mem_oe_n), 32'd1);
    chk("R7", 32'(io_rw), 32'(rw));
    @(posedge phi2);
    #2;
    data = b ^ 8'hA5;
    #4;
    // high phase: held bank, strobes qualified
    chk("R2", 32'(bank_o), 32'(b));
    check_cs(!(da | pa) ? "R1" : (b != 0) ? "R4" : "R3", rgn);
    chk((rgn == 3 && !rw) ? "R9" : "R6", 32'(ram_we_n), 32'(!(rgn == 1 && !rw)));
    chk("R8", 32'(mem_oe_n), 32'(!((rgn == 1 || rgn == 3) && rw)));
    chk("R7", 32'(io_rw), 32'(rw));
  endtask

  task automatic check_idle(input string req);
    chk(req, {24'd0, bank_o}, 32'd0);
    chk(req, {26'd0, rom_cs_n, ram_cs_n, io_cs_n, ram_we_n, mem_oe_n, io_rw}, 32'h3F);
  endtask

  initial begin
    logic [7:0]  banks [4];
    logic [15:0] edges [6];
    banks = '{8'h00, 8'h01, 8'h80, 8'hFF};
    edges = '{16'h0000, 16'h7EFF, 16'h7F00, 16'h7FFF, 16'h8000, 16'hFFFF};

    // R11: outputs idle during reset with a valid RAM write pending
    vda = 1'b1; rwb = 1'b0; addr = 16'h1234; data = 8'h00;
    @(posedge phi2); #4; check_idle("R11");
    @(negedge phi2); #4; check_idle("R11");
    #2; rst_n = 1'b1;
    @(posedge phi2); #4; check_idle("R11");   // first edge after release
    @(negedge phi2); #4; check_idle("R11");
    @(posedge phi2); #4;                       // second edge: active
    chk("R11", 32'(ram_we_n), 32'd0);
    chk("R11", 32'(ram_cs_n), 32'd0);

    for (int bi = 0; bi < 4; bi++) begin
      for (int c = 0; c < 8; c++) begin
        for (int p = 0; p < 256; p++)
          bus_cycle(banks[bi], 16'((p << 8) | ((p * 37) & 8'hFF)), c[0], c[1], c[2]);
        for (int e = 0; e < 6; e++)
          bus_cycle(banks[bi], edges[e], c[0], c[1], c[2]);
      end
    end

    // R11: asynchronous re-entry into reset
    @(posedge phi2); #3; rst_n = 1'b0; #2;
    check_idle("R11");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #2_000_000;
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule